// File: doc/BRIEF.md
# Word-Interleaved Shared Memory Crossbar

This block lets a group of processor ports share one set of single-port memory banks as if the banks were a single multiported memory. Consecutive 32-bit words sit in consecutive banks. Masters that target different banks are all served in the same cycle. When several masters target the same bank in the same cycle, that bank's own round-robin arbiter picks one of them. Each bank is a plain memory with no wait states, held inside the block as a small behavioural array.

Each master port is a valid/ready request channel. `req_ready` is the grant and is computed combinationally in the same cycle as `req_valid`. A request is accepted on a cycle where both are high. While `req_valid` is high and `req_ready` is low, the master must hold the address, the operation and the data unchanged, and it offers the same request again in the next cycle. The response has no back-pressure. One cycle after each acceptance, `rsp_valid` pulses for one cycle together with the word that the bank held before the access. Three kinds of request exist: read, byte-masked write, and an atomic test-and-set. The test-and-set returns the old word and forces its top byte to all ones within the same bank access. The bank count divided by the master count is the banking factor (1, 2 or 4). It trades area for fewer conflicts.

Top module: `xbar_tcdm`

## Requirements
- R1: While reset is low, no grant and no response is given. After reset every memory word holds zero.
- R2: `req_ready[m]` is high only when `req_valid[m]` is high and master m has won the bank it addresses.
- R3: The bank index is taken from address bits [2 +: log2(N_BANKS)] and the row inside the bank from the bits just above them. Address bits [1:0] have no effect.
- R4: Each bank grants at most one master per cycle. Masters that address distinct banks are all granted in the same cycle.
- R5: Each bank's arbiter searches upward from its pointer, wrapping around, and grants the first requester it finds. After a grant the pointer moves to the winner's index plus one, modulo N_MASTERS. The previous winner therefore has the lowest priority.
- R6: `rsp_valid[m]` is high in exactly the cycles that follow an accepted request of master m. `rsp_rdata` then carries the addressed word as it was before that access, for reads, writes and test-and-set alike.
- R7: A write (`req_we`=1, `req_tas`=0) updates byte i of the word only where `req_be[i]`=1. Byte i is bits [8i+7:8i].
- R8: A test-and-set (`req_tas`=1) writes 8'hFF into bits [31:24], keeps bits [23:0], and ignores `req_we`, `req_be` and `req_wdata`.
- R9: After reset every bank pointer is 0, so the first conflict in a bank goes to the lowest-numbered requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_MASTERS | Request present, one bit per master |
| req_ready | output | N_MASTERS | Grant, same cycle as the request |
| req_addr | input | N_MASTERS*ADDR_W | Byte address per master |
| req_we | input | N_MASTERS | Write when high, read when low |
| req_tas | input | N_MASTERS | Test-and-set request |
| req_be | input | N_MASTERS*4 | Byte enables for writes |
| req_wdata | input | N_MASTERS*32 | Write data per master |
| rsp_valid | output | N_MASTERS | Response pulse, one cycle after a grant |
| rsp_rdata | output | N_MASTERS*32 | Word value before the granted access |

## Verification
The hardest case to reach is a bank arbiter whose pointer has to wrap while an earlier loser is still waiting and a new requester arrives. The same difficulty applies to a test-and-set that races a write to the same word in the next cycle. The stimulus starts with four masters that all queue on one bank and hold their requests until served, which walks the pointer through a full rotation. Directed write and test-and-set sequences on one word follow. After that comes long random traffic, first squeezed into a handful of addresses across few banks so that conflicts, retries and back-to-back atomics are frequent, and then spread over the whole address space.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int OFS_W  = $clog2(BYTES);
  localparam logic [7:0] TAS_SET = 8'hFF;

  typedef struct packed {
    logic             we;
    logic             tas;
    logic [BYTES-1:0] be;
    logic [WORD_W-1:0] wdata;
  } bank_op_t;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt,
  output logic [IDX_W-1:0] win,
  output logic             any
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] cand;

  // search upward from the pointer, wrapping (N_REQ is a power of two)
  always_comb begin
    gnt  = '0;
    win  = '0;
    any  = 1'b0;
    cand = '0;
    for (int k = 0; k < N_REQ; k++) begin
      cand = ptr_q + IDX_W'(k);
      if (!any && req[cand]) begin
        any = 1'b1;
        win = cand;
      end
    end
    if (any) gnt[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= win + IDX_W'(1);
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R2
  AST_LAST_WINNER_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (any && $past(any) && req[$past(win)] && $countones(req) > 1)
      |-> (win != $past(win))); // R5
endmodule

// File: rtl/xbar_bank.sv
module xbar_bank
  import xbar_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ROW_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ROW_W-1:0]  row,
  input  bank_op_t          op,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
      rdata <= '0;
    end else if (en) begin
      rdata <= mem[row];
      for (int i = 0; i < BYTES; i++) begin
        if (op.tas) begin
          if (i == BYTES - 1) mem[row][i*8 +: 8] <= TAS_SET;
        end else if (op.we && op.be[i]) begin
          mem[row][i*8 +: 8] <= op.wdata[i*8 +: 8];
        end
      end
    end
  end

  AST_TAS_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op.tas) |=> (mem[$past(row)][WORD_W-1 -: 8] == TAS_SET)); // R8
  AST_READ_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !op.we && !op.tas) |=> (mem[$past(row)] == $past(mem[row]))); // R6
endmodule

// File: rtl/xbar_tcdm.sv
module xbar_tcdm
  import xbar_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int N_BANKS    = 8,
  parameter int BANK_DEPTH = 16,
  parameter int ADDR_W     = 2 + $clog2(N_BANKS) + $clog2(BANK_DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MASTERS-1:0]          req_valid,
  output logic [N_MASTERS-1:0]          req_ready,
  input  logic [N_MASTERS*ADDR_W-1:0]   req_addr,
  input  logic [N_MASTERS-1:0]          req_we,
  input  logic [N_MASTERS-1:0]          req_tas,
  input  logic [N_MASTERS*BYTES-1:0]    req_be,
  input  logic [N_MASTERS*WORD_W-1:0]   req_wdata,
  output logic [N_MASTERS-1:0]          rsp_valid,
  output logic [N_MASTERS*WORD_W-1:0]   rsp_rdata
);
  localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int ROW_W  = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int MIDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] vld;
  logic [BANK_W-1:0]    m_bank [N_MASTERS];
  logic [ROW_W-1:0]     m_row  [N_MASTERS];
  bank_op_t             m_op   [N_MASTERS];

  logic [N_MASTERS-1:0] b_gnt   [N_BANKS];
  logic [MIDX_W-1:0]    b_win   [N_BANKS];
  logic [MIDX_W-1:0]    b_win_q [N_BANKS];
  logic [N_BANKS-1:0]   b_any;
  logic [N_BANKS-1:0]   b_act_q;
  logic [WORD_W-1:0]    b_rdata [N_BANKS];

  assign vld = req_valid & {N_MASTERS{rst_n}};

  // decode: word-level interleaving, byte offset dropped
  always_comb begin
    for (int m = 0; m < N_MASTERS; m++) begin
      m_bank[m]     = req_addr[m*ADDR_W + OFS_W +: BANK_W];
      m_row[m]      = req_addr[m*ADDR_W + OFS_W + BANK_W +: ROW_W];
      m_op[m].we    = req_we[m];
      m_op[m].tas   = req_tas[m];
      m_op[m].be    = req_be[m*BYTES +: BYTES];
      m_op[m].wdata = req_wdata[m*WORD_W +: WORD_W];
    end
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [N_MASTERS-1:0] breq;
    always_comb begin
      for (int m = 0; m < N_MASTERS; m++)
        breq[m] = vld[m] && (m_bank[m] == BANK_W'(b));
    end

    xbar_rr_arb #(.N_REQ(N_MASTERS)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(breq),
      .gnt(b_gnt[b]), .win(b_win[b]), .any(b_any[b])
    );

    xbar_bank #(.DEPTH(BANK_DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .en(b_any[b]),
      .row(m_row[b_win[b]]), .op(m_op[b_win[b]]), .rdata(b_rdata[b])
    );
  end

  // registered winner per bank steers the response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act_q <= '0;
      for (int b = 0; b < N_BANKS; b++) b_win_q[b] <= '0;
    end else begin
      b_act_q <= b_any;
      for (int b = 0; b < N_BANKS; b++) b_win_q[b] <= b_win[b];
    end
  end

  always_comb begin
    req_ready = '0;
    for (int b = 0; b < N_BANKS; b++) req_ready = req_ready | b_gnt[b];
  end

  always_comb begin
    rsp_valid = '0;
    rsp_rdata = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (b_act_q[b]) begin
        rsp_valid[b_win_q[b]] = 1'b1;
        rsp_rdata[int'(b_win_q[b])*WORD_W +: WORD_W] = b_rdata[b];
      end
    end
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R2
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid & req_ready))); // R6
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (req_ready == '0)); // R1
endmodule

// File: tb/tb_xbar_tcdm.sv
`timescale 1ns/1ps
module tb_xbar_tcdm;
  localparam int NM = 4;
  localparam int NB = 8;
  localparam int DEP = 16;
  localparam int AW = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [NM-1:0]   req_valid, req_ready, req_we, req_tas, rsp_valid;
  logic [NM*AW-1:0] req_addr;
  logic [NM*4-1:0]  req_be;
  logic [NM*32-1:0] req_wdata, rsp_rdata;

  xbar_tcdm #(.N_MASTERS(NM), .N_BANKS(NB), .BANK_DEPTH(DEP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_tas(req_tas), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // bench-side request state
  logic          mv [NM];
  logic [AW-1:0] ma [NM];
  logic          mwe[NM], mtas[NM];
  logic [3:0]    mbe[NM];
  logic [31:0]   mwd[NM];
  // reference model
  logic [31:0] ref_mem [NB*DEP];
  int          ref_ptr [NB];
  logic        exp_rv  [NM];
  logic [31:0] exp_rd  [NM];
  string       exp_tag [NM];
  logic        granted [NM];
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, then compare and advance the model
  task automatic step();
    logic eg [NM];
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      req_valid[m] = mv[m];
      req_addr[m*AW +: AW] = ma[m];
      req_we[m] = mwe[m];
      req_tas[m] = mtas[m];
      req_be[m*4 +: 4] = mbe[m];
      req_wdata[m*32 +: 32] = mwd[m];
    end
    #1;
    for (int m = 0; m < NM; m++) begin
      chk("R6 rsp_valid", 32'(rsp_valid[m]), 32'(exp_rv[m]));
      if (exp_rv[m]) chk(exp_tag[m], rsp_rdata[m*32 +: 32], exp_rd[m]);
      eg[m] = 1'b0;
    end
    for (int b = 0; b < NB; b++) begin
      bit found = 0;
      for (int k = 0; k < NM; k++) begin
        int c = (ref_ptr[b] + k) % NM;
        if (!found && mv[c] && int'(ma[c][4:2]) == b) begin
          found = 1; eg[c] = 1'b1; ref_ptr[b] = (c + 1) % NM;
        end
      end
    end
    for (int m = 0; m < NM; m++) begin
      int w = int'(ma[m][4:2]) * DEP + int'(ma[m][8:5]);
      chk("R2/R4/R5 req_ready", 32'(req_ready[m]), 32'(eg[m]));
      exp_rv[m] = eg[m];
      granted[m] = eg[m];
      if (eg[m]) begin
        exp_rd[m] = ref_mem[w];
        if (mtas[m]) begin
          exp_tag[m] = "R8 tas old word";
          ref_mem[w][31:24] = 8'hFF;
        end else if (mwe[m]) begin
          exp_tag[m] = "R7 write old word";
          for (int i = 0; i < 4; i++) if (mbe[m][i]) ref_mem[w][i*8 +: 8] = mwd[m][i*8 +: 8];
        end else exp_tag[m] = "R6 read data";
      end
    end
  endtask

  task automatic set_req(input int m, input logic [AW-1:0] a, input logic we,
                         input logic tas, input logic [3:0] be, input logic [31:0] wd);
    mv[m] = 1'b1; ma[m] = a; mwe[m] = we; mtas[m] = tas; mbe[m] = be; mwd[m] = wd;
  endtask

  task automatic drop_granted();
    for (int m = 0; m < NM; m++) if (granted[m]) mv[m] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_addr = '0; req_we = '0; req_tas = '0; req_be = '0; req_wdata = '0;
    for (int m = 0; m < NM; m++) begin
      mv[m] = 0; ma[m] = '0; mwe[m] = 0; mtas[m] = 0; mbe[m] = '0; mwd[m] = '0;
      exp_rv[m] = 0; exp_rd[m] = '0; exp_tag[m] = ""; granted[m] = 0;
    end
    for (int i = 0; i < NB*DEP; i++) ref_mem[i] = '0;
    for (int b = 0; b < NB; b++) ref_ptr[b] = 0;

    // R1: held in reset with a request offered, nothing granted or answered
    req_valid = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 ready in reset", 32'(req_ready), 32'h0);
    chk("R1 rsp in reset", 32'(rsp_valid), 32'h0);
    req_valid = '0;
    rst_n = 1'b1;

    // R9 + R5: four masters on bank 0, each holds until served
    for (int m = 0; m < NM; m++) set_req(m, AW'(m * 32), 0, 0, 4'h0, 0);
    for (int r = 0; r < NM; r++) begin
      step();
      chk(r == 0 ? "R9 first conflict winner" : "R5 rotation", 32'(req_ready), 32'(1 << r));
      drop_granted();
    end
    // R5 wrap: pointer back at 0, masters 3 and 0 contend
    set_req(3, 9'h000, 0, 0, 0, 0); set_req(0, 9'h020, 0, 0, 0, 0);
    step(); chk("R5 wrap to master 0", 32'(req_ready), 32'h1); drop_granted();
    step(); chk("R5 loser served next", 32'(req_ready), 32'h8); drop_granted();

    // R4 + R1: distinct banks all granted; memory reads zero
    for (int m = 0; m < NM; m++) set_req(m, AW'(m * 4 + 4), 0, 0, 0, 0);
    step(); chk("R4 all distinct banks granted", 32'(req_ready), 32'hF); drop_granted();
    step(); chk("R1 memory zero after reset", rsp_rdata[63:32], 32'h0);

    // R7: masked write then read back
    set_req(1, 9'h024, 1, 0, 4'b0101, 32'h11223344);
    step(); drop_granted();
    set_req(1, 9'h024, 0, 0, 0, 0);
    step(); drop_granted();
    step(); chk("R7 masked write", rsp_rdata[63:32], 32'h00220044);

    // R3: byte offset bits do not change the word
    set_req(2, 9'h027, 0, 0, 0, 0);
    step(); drop_granted();
    step(); chk("R3 byte offset ignored", rsp_rdata[95:64], 32'h00220044);

    // R8: test-and-set back to back on one word, junk be/wdata
    set_req(3, 9'h024, 1, 1, 4'hF, 32'hDEADBEEF);
    step(); drop_granted();
    set_req(0, 9'h024, 0, 1, 4'hF, 32'h0);
    step(); drop_granted();
    chk("R8 tas returns old word", rsp_rdata[127:96], 32'h00220044);
    set_req(2, 9'h024, 0, 0, 0, 0);
    step(); drop_granted();
    chk("R8 second tas sees set byte", rsp_rdata[31:0], 32'hFF220044);
    step(); chk("R8 word after tas", rsp_rdata[95:64], 32'hFF220044);

    // random traffic: narrow window first for heavy conflicts, then wide
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int m = 0; m < NM; m++) begin
        if (!(mv[m] && !granted[m])) begin
          int r = $urandom % 20;
          logic [AW-1:0] a = AW'($urandom);
          if (cyc < 1500) a = a & 9'h06F;
          mv[m] = ($urandom % 4) != 0;
          ma[m] = a;
          mtas[m] = (r >= 17);
          mwe[m] = (r >= 10) && (r < 17);
          mbe[m] = 4'($urandom);
          mwd[m] = $urandom;
        end
      end
      step();
    end
    for (int m = 0; m < NM; m++) mv[m] = 0;
    step();
    step();
    finish_run();
  end
endmodule